// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Bus Controller

This block sits on the host side of a pseudo-static RAM and runs the memory's plain SRAM-style asynchronous bus. After reset it counts out a start-up hold-off of more than 150 µs. During that time it issues no bus cycle. It then reports that it is ready. No configuration write is needed first, because the memory comes up in its asynchronous mode.

A one-beat request port accepts an address, write data, two byte enables and a read/write flag. Each accepted request becomes one single-word bus cycle. A small state machine walks the cycle through address setup, the active strobe window and recovery. A down-counter, loaded from parameters given in system clock cycles, times each phase. A one-cycle done strobe closes every cycle, and for a read it comes with the captured word.

The memory clock is held at a fixed level. The WAIT pin is not used. A configuration input chooses whether the address-valid strobe is a short latch pulse or stays low for the whole access.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset release, `init_done_o` and `req_ready_o` stay low, and `mem_ce_no` stays high, for exactly PWRUP_CYC rising clock edges. From the PWRUP_CYC-th edge on, `init_done_o` is high.
- R2: A request is taken only on an edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only when the hold-off has ended and no cycle is in progress. A request offered while the controller is busy or still starting up leaves no trace: no bus cycle, no done strobe, and no change of `mem_addr_o`.
- R3: In a read, `mem_ce_no` and `mem_oe_no` are low while `mem_we_no` stays high. `mem_oe_no` stays low for exactly RD_ACC_CYC cycles. The data bus is sampled at the edge that ends that window.
- R4: In a write, `mem_ce_no` and `mem_we_no` are low, and `mem_we_no` stays low for exactly WR_PULSE_CYC cycles. `mem_oe_no` is high in every cycle in which `mem_we_no` is low.
- R5: `mem_dq_io` is driven only for writes. It carries the write word from setup through recovery, so the word is still driven in the cycle after `mem_we_no` rises. The bus is released whenever `mem_oe_no` is low.
- R6: Byte lanes: `req_be_i[0]` selects `mem_lb_no`, which covers DQ[7:0], and `req_be_i[1]` selects `mem_ub_no`, which covers DQ[15:8]. A lane strobe is low only while `mem_ce_no` is low and its enable bit is set. A write changes only the enabled bytes.
- R7: With `adv_hold_i`=0, `mem_adv_no` is low only during the SETUP_CYC setup cycles. With `adv_hold_i`=1, it is low for every cycle in which `mem_ce_no` is low. It is always high while `mem_ce_no` is high.
- R8: `mem_clk_o` holds a constant low level. Activity on `mem_wait_i` has no effect on timing or data.
- R9: `mem_ce_no` stays high for at least two cycles between accesses. Two successive falls of `mem_ce_no`, where the first one starts a read, are at least RD_CYC_MIN cycles apart.
- R10: `rsp_done_o` is high for one cycle per access. It is high SETUP_CYC+RD_ACC_CYC edges after acceptance for a read, or SETUP_CYC+WR_PULSE_CYC edges after acceptance for a write. For a read, `rsp_rdata_o` holds the captured word while `rsp_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_hold_i | input | 1 | 1: address strobe held low for the whole access; 0: setup pulse only |
| req_valid_i | input | 1 | Request offered |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | 16 | Write word |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| req_ready_o | output | 1 | Request can be taken this cycle |
| rsp_done_o | output | 1 | One-cycle end-of-access strobe |
| rsp_rdata_o | output | 16 | Read word, valid with done |
| init_done_o | output | 1 | Start-up hold-off elapsed |
| mem_addr_o | output | AW | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lb_no | output | 1 | Low byte strobe, active low |
| mem_ub_no | output | 1 | High byte strobe, active low |
| mem_adv_no | output | 1 | Address valid, active low |
| mem_clk_o | output | 1 | Memory clock, held static |
| mem_wait_i | input | 1 | Memory wait pin, unused |
| mem_dq_io | inout | 16 | Bidirectional data bus |

## Verification
Two events can meet in the same cycle. A request can arrive while the previous access is still raising its done strobe and recovering. The start-up counter can also expire while a request is already being held on the port.

To provoke the first case, the bench pulses a write request during a read's active window and again during its recovery. It judges the result at the ports: the done strobes must match the scoreboard one for one, `mem_addr_o` must stay unchanged, and a later read must return the untouched word. To provoke the second case, a request is raised during the hold-off window. The bench then checks that chip enable never fell before `init_done_o`.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOVER
  } bus_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
  parameter int HOLD_CYC = 30002
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(HOLD_CYC - 1)) ready_o <= 1'b1;
    end
  end

  // R1
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/psram_cycle_fsm.sv
module psram_cycle_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC    = 1,
  parameter int RD_ACC_CYC   = 4,
  parameter int WR_PULSE_CYC = 3,
  parameter int RD_REC_CYC   = 3,
  parameter int WR_REC_CYC   = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       we_i,
  output bus_state_e state_o,
  output logic       we_o,
  output logic       capture_o,
  output logic       done_o
);
  localparam int MAXD = imax(imax(SETUP_CYC, RD_ACC_CYC),
                             imax(WR_PULSE_CYC, imax(RD_REC_CYC, WR_REC_CYC)));
  localparam int CW = $clog2(MAXD) + 1;

  bus_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          we_q;
  logic          done_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SETUP;
          we_q  <= we_i;
          cnt_q <= CW'(SETUP_CYC - 1);
        end
        ST_SETUP: if (last) begin
          st_q  <= ST_ACTIVE;
          cnt_q <= we_q ? CW'(WR_PULSE_CYC - 1) : CW'(RD_ACC_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_ACTIVE: if (last) begin
          st_q   <= ST_RECOVER;
          done_q <= 1'b1;
          cnt_q  <= we_q ? CW'(WR_REC_CYC - 1) : CW'(RD_REC_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_RECOVER: if (last) st_q <= ST_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign we_o      = we_q;
  assign done_o    = done_q;
  assign capture_o = (st_q == ST_ACTIVE) && last && !we_q;

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_in_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_RECOVER));
  // R3
  capture_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> (done_o && !we_q));
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int AW           = 22,
  parameter int PWRUP_CYC    = 30002,
  parameter int SETUP_CYC    = 1,
  parameter int RD_ACC_CYC   = 4,
  parameter int WR_PULSE_CYC = 3,
  parameter int RD_CYC_MIN   = 8,
  parameter int REC_CYC      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_hold_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              init_done_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_lb_no,
  output logic              mem_ub_no,
  output logic              mem_adv_no,
  output logic              mem_clk_o,
  input  logic              mem_wait_i,
  inout  wire  [DATA_W-1:0] mem_dq_io
);
  // read recovery stretched so setup+access+recovery meets the read cycle time
  localparam int RD_REC_CYC = imax(REC_CYC, RD_CYC_MIN - SETUP_CYC - RD_ACC_CYC);
  localparam int WR_REC_CYC = REC_CYC;

  bus_state_e        st;
  logic              cyc_we;
  logic              capture;
  logic              accept;
  logic              ce_act;
  logic              dq_oe;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  lane_n;
  logic              wait_unused;

  assign wait_unused = mem_wait_i;

  psram_pwrup_timer #(.HOLD_CYC(PWRUP_CYC)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(init_done_o)
  );

  psram_cycle_fsm #(
    .SETUP_CYC   (SETUP_CYC),
    .RD_ACC_CYC  (RD_ACC_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC),
    .RD_REC_CYC  (RD_REC_CYC),
    .WR_REC_CYC  (WR_REC_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .we_i     (req_we_i),
    .state_o  (st),
    .we_o     (cyc_we),
    .capture_o(capture),
    .done_o   (rsp_done_o)
  );

  assign req_ready_o = init_done_o && (st == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_io;
  end

  // strobes decoded from registered state only
  assign ce_act     = (st == ST_SETUP) || (st == ST_ACTIVE);
  assign mem_ce_no  = !ce_act;
  assign mem_oe_no  = !((st == ST_ACTIVE) && !cyc_we);
  assign mem_we_no  = !((st == ST_ACTIVE) && cyc_we);
  assign mem_adv_no = !((st == ST_SETUP) || (adv_hold_i && (st == ST_ACTIVE)));
  assign mem_clk_o  = 1'b0;
  assign mem_addr_o = addr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_n[l] = !(ce_act && be_q[l]);
  end
  assign mem_lb_no = lane_n[0];
  assign mem_ub_no = lane_n[1];

  // hold write data through recovery so it outlasts the WE# rising edge
  assign dq_oe       = cyc_we && (st != ST_IDLE);
  assign mem_dq_io   = dq_oe ? wdata_q : {DATA_W{1'bz}};
  assign rsp_rdata_o = rdata_q;

  // R1
  no_early_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> mem_ce_no);
  // R2
  busy_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(mem_addr_o));
  // R4
  we_over_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  // R5
  dq_released_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !dq_oe);
  // R5
  dq_hold_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> dq_oe);
  // R7
  adv_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> mem_adv_no);
  // R9
  ce_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |=> mem_ce_no);
endmodule

// File: tb/psram_async_ctrl_bench.sv
`timescale 1ns/1ps
module psram_async_ctrl_bench;
  localparam int AW = 22, PWR = 30002, SU = 1, ACC = 4, WP = 3, RCMIN = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic adv_hold_i = 1'b0, req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0] req_be_i = '0;
  logic req_ready_o, rsp_done_o, init_done_o;
  logic [15:0] rsp_rdata_o;
  logic [AW-1:0] mem_addr_o;
  logic mem_ce_no, mem_oe_no, mem_we_no, mem_lb_no, mem_ub_no, mem_adv_no, mem_clk_o;
  logic mem_wait_i = 1'b0;
  wire [15:0] dq;

  psram_async_ctrl u_psram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .adv_hold_i(adv_hold_i),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_be_i(req_be_i), .req_ready_o(req_ready_o),
    .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o), .init_done_o(init_done_o),
    .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
    .mem_we_no(mem_we_no), .mem_lb_no(mem_lb_no), .mem_ub_no(mem_ub_no),
    .mem_adv_no(mem_adv_no), .mem_clk_o(mem_clk_o), .mem_wait_i(mem_wait_i),
    .mem_dq_io(dq)
  );

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory model: data valid only once OE# has been low for ACC cycles
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  int oe_cnt = 0;
  assign dq = (!mem_ce_no && !mem_oe_no) ?
              ((oe_cnt >= ACC) ? mem[mem_addr_o[7:0]] : 16'hBAD0) : 16'hzzzz;

  typedef struct { bit we; logic [15:0] data; int due; } exp_t;
  exp_t sb_q[$];
  logic [1:0] cur_be = '0;

  // protocol monitor state
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1, p_lb = 1'b1, p_ub = 1'b1, p_clk = 1'b0;
  int ce_cnt = 0, ce_hi = 0, oe_run = 0, we_run = 0, last_fall = -1000;
  bit last_read = 1'b0, ce_before_init = 1'b0, clk_moved = 1'b0, seen_access = 1'b0;

  always @(negedge clk) begin
    mem_wait_i <= ~mem_wait_i;  // R8: WAIT toggles throughout
    if (rst_ni) begin
      if (mem_clk_o !== p_clk) clk_moved = 1'b1;
      if (!mem_ce_no && !init_done_o) ce_before_init = 1'b1;
      // write latch on WE# rising edge, data must still be driven (R5)
      if (!p_we && mem_we_no) begin
        if (!p_lb) mem[mem_addr_o[7:0]][7:0]  <= dq[7:0];
        if (!p_ub) mem[mem_addr_o[7:0]][15:8] <= dq[15:8];
        check(we_run == WP, "R4 write pulse length", we_run, WP);
      end
      if (!p_oe && mem_oe_no) check(oe_run == ACC, "R3 access window length", oe_run, ACC);
      if (!mem_ce_no) begin
        if (p_ce) begin
          if (seen_access) check(ce_hi >= 2, "R9 CE# high gap", ce_hi, 2);
          if (last_read) check(cyc - last_fall >= RCMIN, "R9 read cycle time", cyc - last_fall, RCMIN);
          last_fall = cyc;
          last_read = 1'b0;
          seen_access = 1'b1;
        end
        check(mem_lb_no == !cur_be[0], "R6 LB# lane", mem_lb_no, !cur_be[0]);
        check(mem_ub_no == !cur_be[1], "R6 UB# lane", mem_ub_no, !cur_be[1]);
        check(mem_adv_no == (adv_hold_i ? 1'b0 : (ce_cnt >= SU)), "R7 ADV# level",
              mem_adv_no, adv_hold_i ? 1'b0 : (ce_cnt >= SU));
        if (!mem_oe_no) begin
          check(mem_we_no, "R3 WE# high during read", mem_we_no, 1);
          last_read = 1'b1;
        end
        if (!mem_we_no) check(mem_oe_no, "R4 OE# high during write", mem_oe_no, 1);
        ce_cnt++; ce_hi = 0;
      end else begin
        if (!mem_adv_no) check(0, "R7 ADV# low with CE# high", mem_adv_no, 1);
        ce_cnt = 0; ce_hi++;
      end
      oe_run = mem_oe_no ? 0 : oe_run + 1;
      we_run = mem_we_no ? 0 : we_run + 1;
      oe_cnt = mem_oe_no ? 0 : oe_cnt + 1;
      p_we = mem_we_no; p_oe = mem_oe_no; p_ce = mem_ce_no;
      p_lb = mem_lb_no; p_ub = mem_ub_no; p_clk = mem_clk_o;
      // scoreboard monitor
      if (rsp_done_o) begin
        if (sb_q.size() == 0) check(0, "R2 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.due, "R10 done timing", cyc, e.due);
          if (!e.we) check(rsp_rdata_o == e.data, "R3 R6 read data", rsp_rdata_o, e.data);
        end
      end
    end
  end

  task automatic issue(bit we, logic [7:0] a, logic [15:0] d, logic [1:0] be);
    exp_t e;
    @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = AW'(a);
    req_wdata_i = d; req_be_i = be;
    while (!req_ready_o) @(negedge clk);
    cur_be = be;
    e.we = we; e.due = cyc + 1 + SU + (we ? WP : ACC); e.data = '0;
    if (we) begin
      if (be[0]) exp_mem[a][7:0]  = d[7:0];
      if (be[1]) exp_mem[a][15:8] = d[15:8];
    end else e.data = exp_mem[a];
    sb_q.push_back(e);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_no && !req_ready_o && !init_done_o && !rsp_done_o, "R1 reset state",
          {mem_ce_no, req_ready_o, init_done_o, rsp_done_o}, 4'b1000);
    rst_ni = 1'b1;
    // R2: request offered during hold-off
    repeat (100) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = AW'(7); req_wdata_i = 16'hDEAD; req_be_i = 2'b11;
    repeat (5) @(negedge clk);
    req_valid_i = 1'b0;
    repeat (PWR - 1 - 105) @(negedge clk);
    check(!init_done_o && !req_ready_o, "R1 not ready before hold-off end",
          {init_done_o, req_ready_o}, 0);
    @(negedge clk);
    check(init_done_o && req_ready_o, "R1 ready at hold-off end", {init_done_o, req_ready_o}, 3);
    check(!ce_before_init, "R1 R2 no access during hold-off", ce_before_init, 0);

    // pulse-mode address strobe
    adv_hold_i = 1'b0;
    issue(1, 8'd1, 16'h1234, 2'b11);
    issue(1, 8'd2, 16'hAB77, 2'b01);
    issue(1, 8'd3, 16'hCD88, 2'b10);
    issue(0, 8'd1, '0, 2'b11);
    issue(0, 8'd2, '0, 2'b11);
    issue(0, 8'd3, '0, 2'b11);
    issue(0, 8'd7, '0, 2'b11);
    drain();
    check(mem[2] == exp_mem[2], "R6 low lane only written", mem[2], exp_mem[2]);

    // held address strobe
    adv_hold_i = 1'b1;
    issue(1, 8'd10, 16'hF00D, 2'b11);
    issue(0, 8'd10, '0, 2'b11);
    issue(0, 8'd11, '0, 2'b01);
    drain();

    // R2: request pulsed while a read is busy, then during recovery
    adv_hold_i = 1'b0;
    issue(0, 8'd20, '0, 2'b11);
    @(negedge clk);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = AW'(4); req_wdata_i = 16'hFFFF; req_be_i = 2'b11;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(mem_addr_o == AW'(20), "R2 address unchanged while busy", mem_addr_o, 20);
    while (!rsp_done_o) @(negedge clk);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(mem_addr_o == AW'(20), "R2 address unchanged in recovery", mem_addr_o, 20);
    drain();
    issue(0, 8'd4, '0, 2'b11);
    drain();
    check(mem[4] == exp_mem[4], "R2 ignored write left memory", mem[4], exp_mem[4]);
    check(!clk_moved && mem_clk_o == 1'b0, "R8 memory clock static", clk_moved, 0);
    check(sb_q.size() == 0, "R10 every access completed", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule